// File: doc/BRIEF.md
# March Memory Self-Test Controller

This block runs March-type test algorithms on a single-port synchronous SRAM that sits next to it. The algorithm is not fixed in the logic. A small instruction store holds it, and the store is loaded through a write port before the test starts. Each instruction word describes one march element: the order in which addresses are visited, how many operations (one to five) are applied at every address, and for each operation whether it reads or writes and whether its data word is all zeros or all ones. The store can hold a six-element static-fault program, or a program that places several operations back to back on one address to catch dynamic faults. Either program runs on the same hardware; only the store contents change.

A `start` pulse runs the program from slot 0. The controller drives the memory address, write data, write enable and read enable from registers. It checks every read against the value the instruction expects. On a mismatch it raises a single-cycle `fail` pulse with the failing address beside it, so a repair unit can capture the address while the test is still running. When the element marked as last has finished, and its final compare is done, `done` goes high. `pass` then reports whether any mismatch was seen.

Top module: `mbist_ctrl`

## Requirements
- R1: The instruction store is written through `prog_we`/`prog_addr`/`prog_data`, and the program runs from slot 0 upward. Each 16-bit word has these fields: bits [1:0] order (0 = ascending, 1 = descending, 2 = either, run as ascending); bits [4:2] operation count; bit 5+i set means operation i is a write, clear means it is a read; bit 10+i is the data value of operation i; bit 15 marks the last element of the program.
- R2: In each element, operations 0 to count-1 are applied in order at one address before the address moves, with count from 1 to 5. All operations of an element, across every address, are issued on consecutive cycles with no gap.
- R3: An ascending element visits addresses 0 to 2^ADDR_W-1. A descending element visits addresses 2^ADDR_W-1 down to 0. Each address is visited exactly once per element.
- R4: A write operation drives all zeros when its data bit is 0 and all ones when it is 1. A read operation expects the same word pattern.
- R5: A read issued in cycle c that returns data different from its expected word produces `fail` high for exactly cycle c+2, with `fail_addr` equal to the read address. A read that matches produces no pulse.
- R6: `done` rises three cycles after the last operation of the last element is issued and stays high until the next start. `pass` is high at that point only if no mismatch occurred during the run, and once low it stays low until a new start.
- R7: A `start` pulse while idle or done restarts the program from slot 0. It clears `done` and sets `pass` from the next cycle.
- R8: After reset, `done`, `pass`, `fail`, `mem_we` and `mem_re` are all low.
- R9: `mem_we` and `mem_re` are never high in the same cycle. No memory access is issued while idle or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the stored program (accepted when idle or done) |
| prog_we | input | 1 | Write strobe for the instruction store |
| prog_addr | input | PC_W | Instruction store slot to write |
| prog_data | input | 16 | Instruction word to store |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable; data is expected on mem_rdata one cycle later |
| mem_rdata | input | DATA_W | Memory read data |
| fail | output | 1 | One-cycle mismatch pulse |
| fail_addr | output | ADDR_W | Address of the most recent mismatch |
| done | output | 1 | Program finished |
| pass | output | 1 | No mismatch seen in the current or last run |

## Verification
Most internal faults show up on the memory-side outputs within a cycle. A wrong operation index, a misdecoded field or an address counter stepping the wrong way changes the address, the operation kind or the write data of the very next access. The bench compares every access against a trace it builds from the stored program. A broken compare pipeline shows up one cycle early or late on `fail` against reads whose mismatch the bench predicts from its own faulty memory model. A broken end-of-program or pass flag shows up three cycles after the final access, when `done` and `pass` are checked.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [1:0] {
    ORD_UP   = 2'd0,
    ORD_DOWN = 2'd1,
    ORD_ANY  = 2'd2,
    ORD_RSVD = 2'd3
  } order_e;

  // One march element; packed MSB first so that bit 15 is the last flag
  typedef struct packed {
    logic       last;
    logic [4:0] val;
    logic [4:0] wr;
    logic [2:0] cnt;
    order_e     ord;
  } uinstr_t;

  localparam int UI_W    = $bits(uinstr_t);
  localparam int MAX_OPS = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_LOAD,
    S_RUN,
    S_DRAIN,
    S_DONE
  } state_e;

endpackage

// File: rtl/mbist_ustore.sv
module mbist_ustore #(
  parameter int PC_W = 4,
  parameter int W    = 16
) (
  input  logic            clk,
  input  logic            we,
  input  logic [PC_W-1:0] waddr,
  input  logic [W-1:0]    wdata,
  input  logic [PC_W-1:0] raddr,
  output logic [W-1:0]    rdata
);
  localparam int SLOTS = 1 << PC_W;

  logic [W-1:0] store [SLOTS];

  // Simple dual-port RAM with a registered read, no reset on the array
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end

endmodule

// File: rtl/mbist_addr.sv
module mbist_addr #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              down,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] addr_q;
  logic              down_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      addr_q <= down ? TOP : '0;
      down_q <= down;
    end else if (step) begin
      addr_q <= down_q ? addr_q - 1'b1 : addr_q + 1'b1;
    end
  end

  assign addr = addr_q;
  assign last = down_q ? (addr_q == '0) : (addr_q == TOP);

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chk,
  input  logic              exp_bit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] rdata,
  output logic              mismatch,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  logic              v_q;
  logic              e_q;
  logic [ADDR_W-1:0] a_q;

  // Stage aligned with the memory's read: captures what the read expects
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      e_q <= 1'b0;
      a_q <= '0;
    end else begin
      v_q <= chk;
      e_q <= exp_bit;
      a_q <= addr;
    end
  end

  assign mismatch = v_q && (rdata != {DATA_W{e_q}});

  always_ff @(posedge clk) begin
    if (rst) begin
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      fail <= mismatch;
      if (mismatch) fail_addr <= a_q;
    end
  end

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int PC_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  uinstr_t         ins_rd,
  output logic [PC_W-1:0] pc,
  output logic            addr_load,
  output logic            addr_down,
  output logic            addr_step,
  input  logic            addr_last,
  output logic            issue,
  output logic            issue_wr,
  output logic            issue_bit,
  output logic            start_ok,
  output logic            done
);
  localparam logic [1:0] DRAIN_END = 2'd2;

  state_e          state_q, state_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [2:0]      op_q, op_d;
  uinstr_t         ins_q, ins_d;
  logic [1:0]      drain_q, drain_d;
  logic            done_q;
  logic [2:0]      n_ops;
  logic [7:0]      wr_ext, val_ext;

  // Count outside 1..5 is clamped into range
  always_comb begin
    if (ins_q.cnt == 3'd0)                  n_ops = 3'd1;
    else if (ins_q.cnt > 3'(MAX_OPS))       n_ops = 3'(MAX_OPS);
    else                                    n_ops = ins_q.cnt;
  end

  assign wr_ext  = {3'b000, ins_q.wr};
  assign val_ext = {3'b000, ins_q.val};
  assign start_ok = start && (state_q == S_IDLE || state_q == S_DONE);

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    op_d      = op_q;
    ins_d     = ins_q;
    drain_d   = drain_q;
    addr_load = 1'b0;
    addr_down = 1'b0;
    addr_step = 1'b0;
    issue     = 1'b0;
    issue_wr  = 1'b0;
    issue_bit = 1'b0;
    unique case (state_q)
      S_IDLE, S_DONE: begin
        if (start) begin
          pc_d    = '0;
          state_d = S_FETCH;
        end
      end
      S_FETCH: state_d = S_LOAD;
      S_LOAD: begin
        ins_d     = ins_rd;
        addr_load = 1'b1;
        addr_down = (ins_rd.ord == ORD_DOWN);
        op_d      = '0;
        state_d   = S_RUN;
      end
      S_RUN: begin
        issue     = 1'b1;
        issue_wr  = wr_ext[op_q];
        issue_bit = val_ext[op_q];
        if (op_q == n_ops - 3'd1) begin
          op_d = '0;
          if (addr_last) begin
            if (ins_q.last) begin
              drain_d = '0;
              state_d = S_DRAIN;
            end else begin
              pc_d    = pc_q + 1'b1;
              state_d = S_FETCH;
            end
          end else begin
            addr_step = 1'b1;
          end
        end else begin
          op_d = op_q + 3'd1;
        end
      end
      S_DRAIN: begin
        drain_d = drain_q + 2'd1;
        if (drain_q == DRAIN_END) state_d = S_DONE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      op_q    <= '0;
      ins_q   <= '0;
      drain_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      op_q    <= op_d;
      ins_q   <= ins_d;
      drain_q <= drain_d;
      done_q  <= (state_d == S_DONE);
    end
  end

  assign pc   = pc_q;
  assign done = done_q;

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int PC_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              prog_we,
  input  logic [PC_W-1:0]   prog_addr,
  input  logic [UI_W-1:0]   prog_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic              done,
  output logic              pass
);
  logic [PC_W-1:0]   pc;
  logic [UI_W-1:0]   ucode_q;
  uinstr_t           ins_rd;
  logic              addr_load, addr_down, addr_step, addr_last;
  logic [ADDR_W-1:0] cur_addr;
  logic              issue, issue_wr, issue_bit, start_ok;
  logic              mismatch;

  logic [ADDR_W-1:0] mem_addr_q;
  logic [DATA_W-1:0] mem_wdata_q;
  logic              mem_we_q, mem_re_q, exp_bit_q, pass_q;

  mbist_ustore #(.PC_W(PC_W), .W(UI_W)) u_store (
    .clk   (clk),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (pc),
    .rdata (ucode_q)
  );

  assign ins_rd = uinstr_t'(ucode_q);

  mbist_seq #(.PC_W(PC_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ins_rd    (ins_rd),
    .pc        (pc),
    .addr_load (addr_load),
    .addr_down (addr_down),
    .addr_step (addr_step),
    .addr_last (addr_last),
    .issue     (issue),
    .issue_wr  (issue_wr),
    .issue_bit (issue_bit),
    .start_ok  (start_ok),
    .done      (done)
  );

  mbist_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk  (clk),
    .rst  (rst),
    .load (addr_load),
    .down (addr_down),
    .step (addr_step),
    .addr (cur_addr),
    .last (addr_last)
  );

  // Registered memory-side outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
      mem_we_q    <= 1'b0;
      mem_re_q    <= 1'b0;
      exp_bit_q   <= 1'b0;
    end else begin
      mem_addr_q  <= cur_addr;
      mem_wdata_q <= {DATA_W{issue_bit}};
      mem_we_q    <= issue & issue_wr;
      mem_re_q    <= issue & ~issue_wr;
      exp_bit_q   <= issue_bit;
    end
  end

  mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .chk       (mem_re_q),
    .exp_bit   (exp_bit_q),
    .addr      (mem_addr_q),
    .rdata     (mem_rdata),
    .mismatch  (mismatch),
    .fail      (fail),
    .fail_addr (fail_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)           pass_q <= 1'b0;
    else if (start_ok) pass_q <= 1'b1;
    else if (mismatch) pass_q <= 1'b0;
  end

  assign mem_addr  = mem_addr_q;
  assign mem_wdata = mem_wdata_q;
  assign mem_we    = mem_we_q;
  assign mem_re    = mem_re_q;
  assign pass      = pass_q;

endmodule

// File: rtl/mbist_ctrl_chk.sv
module mbist_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic              mem_re,
  input logic              fail,
  input logic              done,
  input logic              pass
);

  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  p_quiet_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_we && !mem_re));

  p_fail_read_r5: assert property (@(posedge clk) disable iff (rst)
    fail |-> $past(mem_re, 2));

  p_fail_pass_r6: assert property (@(posedge clk) disable iff (rst)
    fail |-> !pass);

  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  p_pass_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (!pass && !start) |=> !pass);

  p_wdata_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == '0 || mem_wdata == '1));

  // Address is a single-port index; reported only to keep the port used
  p_addr_known_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> !$isunknown(mem_addr));

endmodule

bind mbist_ctrl mbist_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .fail      (fail),
  .done      (done),
  .pass      (pass)
);

// File: tb/tb_mbist_ctrl.sv
module tb_mbist_ctrl;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int PW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int SLOTS = 1 << PW;
  localparam int MAXE  = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          prog_we = 1'b0;
  logic [PW-1:0] prog_addr = '0;
  logic [15:0]   prog_data = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we, mem_re;
  logic [DW-1:0] mem_rdata = '0;
  logic          fail;
  logic [AW-1:0] fail_addr;
  logic          done, pass;

  always #4 clk = ~clk;

  mbist_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PC_W(PW)) dut (
    .clk(clk), .rst(rst), .start(start),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .fail(fail), .fail_addr(fail_addr),
    .done(done), .pass(pass)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Memory model with one stuck-at-0 and one stuck-at-1 injection point
  logic [DW-1:0] mem [DEPTH];
  int            s0_addr = -1, s1_addr = -1;
  logic [DW-1:0] s0_mask = '0, s1_mask = '0;

  function automatic logic [DW-1:0] faulty(input int a, input logic [DW-1:0] v);
    logic [DW-1:0] r;
    r = v;
    if (a == s0_addr) r = r & ~s0_mask;
    if (a == s1_addr) r = r | s1_mask;
    return r;
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= faulty(int'(mem_addr), mem[mem_addr]);
  end

  // Program and its expected access trace (R1 field layout)
  logic [15:0] prog [SLOTS];
  int          n_exp;
  int          e_addr [MAXE];
  bit          e_we [MAXE];
  bit          e_bit [MAXE];
  bit          e_new [MAXE];

  function automatic logic [15:0] mk(input int ord, input int cnt, input logic [4:0] wr,
                                     input logic [4:0] val, input bit last);
    return {last, val, wr, 3'(cnt), 2'(ord)};
  endfunction

  task automatic build_trace();
    n_exp = 0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int k = 0; k < DEPTH; k++) begin
        int a;
        a = (prog[s][1:0] == 2'd1) ? DEPTH - 1 - k : k;
        for (int o = 0; o < int'(prog[s][4:2]); o++) begin
          e_addr[n_exp] = a;
          e_we[n_exp]   = prog[s][5 + o];
          e_bit[n_exp]  = prog[s][10 + o];
          e_new[n_exp]  = (k == 0 && o == 0);
          n_exp++;
        end
      end
      if (prog[s][15]) break;
    end
  endtask

  task automatic load_prog();
    for (int s = 0; s < SLOTS; s++) begin
      @(negedge clk);
      prog_we   = 1'b1;
      prog_addr = PW'(s);
      prog_data = prog[s];
    end
    @(negedge clk);
    prog_we = 1'b0;
    build_trace();
  endtask

  // Monitor: trace compare and fail prediction
  int            op_idx = 0, last_op_cyc = 0, n_pred = 0, n_seen = 0, done_cyc = 0;
  bit            pv1 = 0, pv2 = 0, done_seen = 0;
  int            pa1 = 0, pa2 = 0;
  logic [DW-1:0] got;

  always @(negedge clk) begin
    if (!rst) begin
      if (fail || pv2) begin
        chk(fail === pv2, "R5", "fail pulse", fail, pv2);
        if (pv2) chk(int'(fail_addr) == pa2, "R5", "fail address", fail_addr, pa2);
      end
      if (fail) n_seen++;
      pv2 = pv1; pa2 = pa1; pv1 = 0; pa1 = 0;
      if (mem_we && mem_re) chk(0, "R9", "write and read together", 1, 0);
      if (mem_we || mem_re) begin
        if (op_idx >= n_exp) begin
          chk(0, "R9", "access outside program", op_idx, n_exp);
        end else begin
          chk(int'(mem_addr) == e_addr[op_idx], "R3", "access address", mem_addr, e_addr[op_idx]);
          chk(mem_we == e_we[op_idx], "R2", "operation kind", mem_we, e_we[op_idx]);
          if (mem_we)
            chk(mem_wdata == {DW{e_bit[op_idx]}}, "R4", "write data", mem_wdata, {DW{e_bit[op_idx]}});
          if (!e_new[op_idx])
            chk(cyc == last_op_cyc + 1, "R2", "back-to-back issue", cyc, last_op_cyc + 1);
          if (mem_re) begin
            got = faulty(int'(mem_addr), mem[mem_addr]);
            pv1 = (got != {DW{e_bit[op_idx]}});
            pa1 = int'(mem_addr);
            if (pv1) n_pred++;
          end
        end
        last_op_cyc = cyc;
        op_idx++;
      end
      if (done && !done_seen) begin
        done_seen = 1;
        done_cyc  = cyc;
      end
    end
  end

  task automatic run_test(input int exp_fails, input bit exp_pass);
    int t;
    op_idx = 0; n_pred = 0; n_seen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    done_seen = 0;
    chk(done === 1'b0, "R7", "done cleared by start", done, 0);
    chk(pass === 1'b1, "R7", "pass set by start", pass, 1);
    t = 0;
    while (!done_seen && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (!done_seen) chk(0, "R6", "watchdog expired", t, 20000);
    repeat (4) @(negedge clk);
    chk(op_idx == n_exp, "R2", "access count", op_idx, n_exp);
    chk(done_cyc == last_op_cyc + 3, "R6", "done latency", done_cyc, last_op_cyc + 3);
    chk(n_pred == exp_fails, "R5", "mismatching reads", n_pred, exp_fails);
    chk(n_seen == exp_fails, "R5", "fail pulses", n_seen, exp_fails);
    chk(pass === exp_pass, "R6", "pass result", pass, exp_pass);
    chk(done === 1'b1, "R6", "done held", done, 1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    for (int s = 0; s < SLOTS; s++) prog[s] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done === 1'b0, "R8", "done after reset", done, 0);
    chk(pass === 1'b0, "R8", "pass after reset", pass, 0);
    chk(fail === 1'b0, "R8", "fail after reset", fail, 0);
    chk(mem_we === 1'b0 && mem_re === 1'b0, "R8", "memory idle after reset", {mem_we, mem_re}, 0);

    // R1: six-element static-fault program
    prog[0] = mk(2, 1, 5'b00001, 5'b00000, 0);
    prog[1] = mk(0, 5, 5'b10100, 5'b10000, 0);
    prog[2] = mk(0, 5, 5'b10100, 5'b01111, 0);
    prog[3] = mk(1, 5, 5'b10100, 5'b10000, 0);
    prog[4] = mk(1, 5, 5'b10100, 5'b01111, 0);
    prog[5] = mk(2, 1, 5'b00000, 5'b00000, 1);
    load_prog();
    chk(n_exp == 22 * DEPTH, "R1", "trace length of static program", n_exp, 22 * DEPTH);
    run_test(0, 1'b1);

    // R5: stuck-at-0 on bit 0 at address 5: three r1 reads in each of two elements
    s0_addr = 5; s0_mask = 8'h01;
    run_test(6, 1'b0);
    s0_addr = -1; s0_mask = '0;

    // R1: different program, back-to-back operations, mixed counts and orders
    for (int s = 0; s < SLOTS; s++) prog[s] = '0;
    prog[0] = mk(1, 1, 5'b00001, 5'b00001, 0);
    prog[1] = mk(0, 3, 5'b00010, 5'b00001, 0);
    prog[2] = mk(2, 2, 5'b00001, 5'b00011, 0);
    prog[3] = mk(1, 4, 5'b00110, 5'b00001, 1);
    load_prog();
    chk(n_exp == 10 * DEPTH, "R1", "trace length of dynamic program", n_exp, 10 * DEPTH);
    run_test(0, 1'b1);

    // R5: stuck-at-1 on bit 7 at the top address: one r0 in each of two elements
    s1_addr = DEPTH - 1; s1_mask = 8'h80;
    run_test(2, 1'b0);
    s1_addr = -1; s1_mask = '0;

    // R7: restart after a failing run recovers pass
    run_test(0, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    errors++;
    checks++;
    $display("FAIL R6 global watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule